// File: doc/BRIEF.md
# Universal Latch-Register Bus Transceiver

This block moves data both ways between two 18-bit ports, A and B. Each direction has its own storage cell. At run time, a latch-enable input and a slow control clock set that cell to one of three behaviours: it follows its input, it holds its contents, or it captures on a falling edge. All of these control inputs are sampled against one fast system clock. No latches and no gated clocks are inferred.

Each tristate pin is modelled in synthesizable form. It has a drive-data bus, a drive-enable bit, and an external driver input (value plus valid). These resolve into the level seen on the port. The A-to-B output enable is active high. The B-to-A output enable is active low. When neither this block nor the outside world drives a port, a bus-hold keeper on that port repeats the last driven level.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage cells, both drive enables and both keepers clear to zero. After reset, an undriven port reads zero.
- R2: If `le_ab` is high at a clock edge, the A-to-B cell loads `a_lvl`. The new value appears on `b_drv_dat` after that edge. B-to-A behaves the same with `le_ba`, `b_lvl` and `a_drv_dat`.
- R3: If the latch enable is low and the direction's control clock is sampled at the same level (high or low) on two consecutive edges, the cell keeps its value.
- R4: If the latch enable is low and the control clock is sampled high at one edge and low at the next, the cell loads the port level at the later edge.
- R5: A low-to-high change of the control clock with the latch enable low does not load the cell.
- R6: `oe_ab` is active high. `b_drv_en` equals `oe_ab` as sampled at the previous clock edge.
- R7: `oe_ba_n` is active low. `a_drv_en` equals the inverse of `oe_ba_n` as sampled at the previous clock edge.
- R8: A port level is chosen in this order: the block's own drive data if its drive enable is 1; otherwise the external data if the external valid bit is 1; otherwise the keeper value.
- R9: While a port is driven by neither side, its level stays at the last level it had while driven.
- R10: With both directions enabled, each port drives only from its own direction's cell. A drives the B-to-A contents and B drives the A-to-B contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control |
| rst | input | 1 | Synchronous active-high reset |
| oe_ab | input | 1 | B port output enable, active high |
| le_ab | input | 1 | A-to-B latch enable |
| ck_ab | input | 1 | A-to-B control clock, capture on its fall |
| oe_ba_n | input | 1 | A port output enable, active low |
| le_ba | input | 1 | B-to-A latch enable |
| ck_ba | input | 1 | B-to-A control clock, capture on its fall |
| a_ext_dat | input | W | Value an outside driver puts on port A |
| a_ext_en | input | 1 | Outside driver on port A is active |
| b_ext_dat | input | W | Value an outside driver puts on port B |
| b_ext_en | input | 1 | Outside driver on port B is active |
| a_drv_dat | output | W | Data this block drives onto port A |
| a_drv_en | output | 1 | This block drives port A |
| b_drv_dat | output | W | Data this block drives onto port B |
| b_drv_en | output | 1 | This block drives port B |
| a_lvl | output | W | Resolved level on port A |
| b_lvl | output | W | Resolved level on port B |

## Verification
The bench builds the block with its default width, W = 18. Its patterns therefore reach the top bit and values such as all-ones and alternating bits. A stuck or misrouted high bit would be visible in them. Slow control clocks are driven as plain inputs, a few system cycles per level. This puts held-high, held-low, rising and falling sequences, one after another, within a single short vector walk.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int DEF_W = 18;

  typedef struct packed {
    logic le;
    logic ck;
  } store_ctl_t;
endpackage

// File: rtl/ubt_store_cell.sv
module ubt_store_cell
  import ubt_pkg::*;
#(
  parameter int W = DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  store_ctl_t   ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic ck_q;
  logic fall;

  // previous control clock level, tracked even in reset
  always_ff @(posedge clk) ck_q <= ctl.ck;

  assign fall = ck_q & ~ctl.ck;

  always_ff @(posedge clk) begin
    if (rst)                 q <= '0;
    else if (ctl.le || fall) q <= d;
  end
endmodule

// File: rtl/ubt_out_drive.sv
module ubt_out_drive #(
  parameter int W        = 18,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe,
  input  logic [W-1:0] q,
  output logic [W-1:0] drv_dat,
  output logic         drv_en
);
  logic act;

  generate
    if (ACT_HIGH) begin : g_hi
      assign act = oe;
    end else begin : g_lo
      assign act = ~oe;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) drv_en <= 1'b0;
    else     drv_en <= act;
  end

  assign drv_dat = q;
endmodule

// File: rtl/ubt_keeper.sv
module ubt_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         own_en,
  input  logic [W-1:0] own_dat,
  input  logic         ext_en,
  input  logic [W-1:0] ext_dat,
  output logic [W-1:0] lvl
);
  logic [W-1:0] keep;

  always_comb begin
    if (own_en)      lvl = own_dat;
    else if (ext_en) lvl = ext_dat;
    else             lvl = keep;
  end

  always_ff @(posedge clk) begin
    if (rst)                   keep <= '0;
    else if (own_en || ext_en) keep <= lvl;
  end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int W = DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_ab,
  input  logic         le_ab,
  input  logic         ck_ab,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         ck_ba,
  input  logic [W-1:0] a_ext_dat,
  input  logic         a_ext_en,
  input  logic [W-1:0] b_ext_dat,
  input  logic         b_ext_en,
  output logic [W-1:0] a_drv_dat,
  output logic         a_drv_en,
  output logic [W-1:0] b_drv_dat,
  output logic         b_drv_en,
  output logic [W-1:0] a_lvl,
  output logic [W-1:0] b_lvl
);
  store_ctl_t   ctl_ab, ctl_ba;
  logic [W-1:0] q_ab, q_ba;

  assign ctl_ab = '{le: le_ab, ck: ck_ab};
  assign ctl_ba = '{le: le_ba, ck: ck_ba};

  ubt_store_cell #(.W(W)) u_cell_ab (
    .clk(clk), .rst(rst), .ctl(ctl_ab), .d(a_lvl), .q(q_ab)
  );
  ubt_store_cell #(.W(W)) u_cell_ba (
    .clk(clk), .rst(rst), .ctl(ctl_ba), .d(b_lvl), .q(q_ba)
  );

  ubt_out_drive #(.W(W), .ACT_HIGH(1'b1)) u_drv_b (
    .clk(clk), .rst(rst), .oe(oe_ab), .q(q_ab),
    .drv_dat(b_drv_dat), .drv_en(b_drv_en)
  );
  ubt_out_drive #(.W(W), .ACT_HIGH(1'b0)) u_drv_a (
    .clk(clk), .rst(rst), .oe(oe_ba_n), .q(q_ba),
    .drv_dat(a_drv_dat), .drv_en(a_drv_en)
  );

  ubt_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst(rst), .own_en(a_drv_en), .own_dat(a_drv_dat),
    .ext_en(a_ext_en), .ext_dat(a_ext_dat), .lvl(a_lvl)
  );
  ubt_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst(rst), .own_en(b_drv_en), .own_dat(b_drv_dat),
    .ext_en(b_ext_en), .ext_dat(b_ext_dat), .lvl(b_lvl)
  );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_ab,
  input logic         le_ab,
  input logic         ck_ab,
  input logic         oe_ba_n,
  input logic         a_ext_en,
  input logic         b_ext_en,
  input logic [W-1:0] a_drv_dat,
  input logic         a_drv_en,
  input logic [W-1:0] b_drv_dat,
  input logic         b_drv_en,
  input logic [W-1:0] a_lvl,
  input logic [W-1:0] b_lvl
);
  logic run_q;
  always_ff @(posedge clk) run_q <= !rst;

  // R2
  load_on_le_chk: assert property (@(posedge clk) disable iff (rst)
    le_ab |=> b_drv_dat == $past(a_lvl));

  // R3
  hold_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !le_ab && !($past(ck_ab) && !ck_ab)) |=> $stable(b_drv_dat));

  // R6
  oe_hi_chk: assert property (@(posedge clk) disable iff (rst)
    oe_ab |=> b_drv_en);

  // R7
  oe_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_ba_n |=> a_drv_en);

  // R8
  own_wins_chk: assert property (@(posedge clk) disable iff (rst)
    b_drv_en |-> b_lvl == b_drv_dat);

  // R9
  keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !a_drv_en && !a_ext_en) |-> a_lvl == $past(a_lvl));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .oe_ab(oe_ab), .le_ab(le_ab), .ck_ab(ck_ab),
  .oe_ba_n(oe_ba_n), .a_ext_en(a_ext_en), .b_ext_en(b_ext_en),
  .a_drv_dat(a_drv_dat), .a_drv_en(a_drv_en), .b_drv_dat(b_drv_dat),
  .b_drv_en(b_drv_en), .a_lvl(a_lvl), .b_lvl(b_lvl)
);

// File: tb/sim_ubt_xcvr.sv
module sim_ubt_xcvr;
  localparam int  W      = 18;
  localparam time TCLK   = 10ns;
  localparam int  NV     = 10;

  // {le_ab, ck_ab, a value, expected b_drv_dat after one edge}
  localparam logic [2*W+1:0] VEC [NV] = '{
    {1'b1, 1'b0, 18'h12345, 18'h12345},  // R2 follow
    {1'b1, 1'b0, 18'h00abc, 18'h00abc},  // R2 follow
    {1'b0, 1'b0, 18'h3ffff, 18'h00abc},  // R3 steady low
    {1'b0, 1'b1, 18'h11111, 18'h00abc},  // R5 rise
    {1'b0, 1'b1, 18'h22222, 18'h00abc},  // R3 steady high
    {1'b0, 1'b0, 18'h15555, 18'h15555},  // R4 fall
    {1'b0, 1'b0, 18'h2aaaa, 18'h15555},  // R3 low
    {1'b0, 1'b1, 18'h00001, 18'h15555},  // R5 rise
    {1'b0, 1'b0, 18'h00002, 18'h00002},  // R4 fall
    {1'b1, 1'b1, 18'h3ffff, 18'h3ffff}   // R2 with ck high
  };

  logic clk = 1'b0, rst = 1'b1;
  logic oe_ab = 0, le_ab = 0, ck_ab = 0;
  logic oe_ba_n = 1, le_ba = 0, ck_ba = 0;
  logic [W-1:0] a_ext_dat = '0, b_ext_dat = '0;
  logic a_ext_en = 0, b_ext_en = 0;
  logic [W-1:0] a_drv_dat, b_drv_dat, a_lvl, b_lvl;
  logic a_drv_en, b_drv_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  ubt_xcvr #(.W(W)) u0 (
    .clk(clk), .rst(rst), .oe_ab(oe_ab), .le_ab(le_ab), .ck_ab(ck_ab),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ck_ba(ck_ba),
    .a_ext_dat(a_ext_dat), .a_ext_en(a_ext_en),
    .b_ext_dat(b_ext_dat), .b_ext_en(b_ext_en),
    .a_drv_dat(a_drv_dat), .a_drv_en(a_drv_en),
    .b_drv_dat(b_drv_dat), .b_drv_en(b_drv_en),
    .a_lvl(a_lvl), .b_lvl(b_lvl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 a_lvl", 32'(a_lvl), 0);
    chk("R1 b_lvl", 32'(b_lvl), 0);
    chk("R1 b_drv_en", 32'(b_drv_en), 0);
    chk("R1 a_drv_en", 32'(a_drv_en), 0);
    chk("R1 b_drv_dat", 32'(b_drv_dat), 0);

    a_ext_en = 1'b1;
    oe_ab    = 1'b1;
    step();
    // R6 enable, active high
    chk("R6 b_drv_en on", 32'(b_drv_en), 1);

    for (int i = 0; i < NV; i++) begin
      {le_ab, ck_ab, a_ext_dat} = VEC[i][2*W+1:W];
      step();
      chk($sformatf("R2-R5 vec%0d b_drv_dat", i), 32'(b_drv_dat), 32'(VEC[i][W-1:0]));
      chk($sformatf("R8 vec%0d b_lvl", i), 32'(b_lvl), 32'(VEC[i][W-1:0]));
    end

    le_ab = 1'b0;            // ck_ab remains high: no capture
    oe_ab = 1'b0;
    step();
    // R6 off, R9 keeper on B holds last own-driven level
    chk("R6 b_drv_en off", 32'(b_drv_en), 0);
    chk("R9 b_lvl kept", 32'(b_lvl), 32'h3ffff);

    b_ext_en = 1'b1; b_ext_dat = 18'h0f0f0; le_ba = 1'b1;
    step();
    chk("R2 ba follow", 32'(a_drv_dat), 32'h0f0f0);
    chk("R7 a_drv_en still off", 32'(a_drv_en), 0);
    oe_ba_n = 1'b0;
    step();
    // R7 active low; R8 own drive beats outside driver on A
    chk("R7 a_drv_en on", 32'(a_drv_en), 1);
    chk("R8 a_lvl own", 32'(a_lvl), 32'h0f0f0);

    le_ba = 1'b0; ck_ba = 1'b1; b_ext_dat = 18'h00777;
    step();
    chk("R5 ba rise no load", 32'(a_drv_dat), 32'h0f0f0);
    ck_ba = 1'b0;
    step();
    chk("R4 ba fall load", 32'(a_drv_dat), 32'h00777);

    oe_ba_n = 1'b1; a_ext_en = 1'b0;
    step();
    chk("R7 a_drv_en off", 32'(a_drv_en), 0);
    step();
    // R9 keeper on A
    chk("R9 a_lvl kept", 32'(a_lvl), 32'h00777);
    chk("R3 ab held", 32'(b_drv_dat), 32'h3ffff);

    oe_ab = 1'b1; oe_ba_n = 1'b0;
    step();
    // R10 each port from its own cell
    chk("R10 b_drv_dat", 32'(b_drv_dat), 32'h3ffff);
    chk("R10 a_drv_dat", 32'(a_drv_dat), 32'h00777);
    chk("R8 b_lvl own over ext", 32'(b_lvl), 32'h3ffff);

    rst = 1'b1;
    step();
    rst = 1'b0; a_ext_en = 0; b_ext_en = 0;
    step();
    chk("R1 re-reset b_drv_dat", 32'(b_drv_dat), 0);
    chk("R1 re-reset a_lvl", 32'(a_lvl), 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule